// File: doc/BRIEF.md
# Dual-Port Parallel I/O Controller

This peripheral gives a CPU two 8-bit parallel ports, A and B. Each port has a ready output and a strobe input for handshaking. The CPU reaches the block through four registers: a data register and a control register for each port. Active-low chip select, read, I/O request and M1 strobes qualify each bus cycle. Every port can work in one of four modes:

- output with handshake
- input with handshake
- bidirectional (port A only)
- bit mode, where each line is an input or an output on its own

In the bidirectional mode, port A uses its own handshake pair for outgoing data and takes port B's pair for incoming data. Port B is then held to bit mode.

In bit mode, a mask picks which lines are watched for an interrupt. The watched lines are combined with AND or OR, and all of them are compared against one programmed level. In the handshake modes, a finished strobe raises the interrupt request instead.

There is no separate reset pin. The block resets itself when M1 is seen low while both read and I/O request are high. Bus cycles are synchronous. A write is taken at each clock edge where it is qualified. Read data is presented combinationally.

Top module: `dual_pio`

## Requirements
- R1: Address 0 selects port A data, address 1 port B data, address 2 port A control and address 3 port B control. A write is taken at each rising edge where cs_n and iorq_n are low and rd_n and m1_n are high. A read, with rd_n also low, drives dout combinationally. A control register reads as 0x00, and dout is 0x00 when no read is in progress.
- R2: An edge with m1_n low and rd_n and iorq_n high resets the block. Both ports go to input mode with no pins driven. Both ready lines go low, and the data registers, mask and interrupt settings go to zero. The direction word goes to all inputs, and irq goes low.
- R3: A control word whose bits 3..0 are 1111 is a mode word. Bits 7..6 give the mode: 0 output, 1 input, 2 bidirectional, 3 bit. A control word matching neither 1111 nor 0111 in bits 3..0, when no follow-up word is pending, is ignored.
- R4: In output mode the port drives all eight pins from its output register. A data write raises ready at that edge. Ready drops at the first edge where the strobe is sampled low after being high. The pins change only on a data write.
- R5: In input mode, ready is high on entering the mode and after each CPU read of the data register. A strobe falling edge latches the pins into the input register and drops ready.
- R6: In bidirectional mode, port A drives its pins only while a_stb_n is low. A data write raises a_rdy, and a falling a_stb_n drops it. A falling b_stb_n latches the port A pins into port A's input register and drops b_rdy. A CPU read of port A data raises b_rdy.
- R7: A mode-2 word for port A is ignored unless port B is in bit mode. A mode-2 word for port B is always ignored. While port A is in mode 2, port B mode words other than mode 3 are ignored.
- R8: The control write after a mode-3 word is the direction word, where bit value 1 makes the line an input. Output enable is the inverse of the direction word. A data read returns the pins on input lines and the output register on output lines.
- R9: A control word with bits 3..0 = 0111 is an interrupt word. Bit 7 enables interrupts, bit 6 selects AND (1) or OR (0), and bit 5 selects active-high (1) or active-low (0). Bit 4 set means the next control write is the mask, where a 1 marks a watched line. An interrupt word clears any pending handshake interrupt of that port.
- R10: In bit mode with interrupts enabled, irq goes high at the edge after the masked condition becomes true and goes low at the edge after it becomes false. An AND over an empty mask is never true.
- R11: In a handshake mode with interrupts enabled, a strobe rising edge sets a pending interrupt, and irq is high from that edge on. The pending interrupt clears on a read or write of that port's data register, or on a mode word for that port.
- R12: With interrupts disabled, a port never raises irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cs_n | input | 1 | Chip select, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | M1 strobe, active low; alone it resets the block |
| addr | input | 2 | Register select |
| din | input | 8 | CPU write data |
| dout | output | 8 | CPU read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A pin drive values |
| pa_oe | output | 8 | Port A per-line output enable |
| a_rdy | output | 1 | Port A ready |
| a_stb_n | input | 1 | Port A strobe, active low |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B pin drive values |
| pb_oe | output | 8 | Port B per-line output enable |
| b_rdy | output | 1 | Port B ready (input-side ready of port A in mode 2) |
| b_stb_n | input | 1 | Port B strobe (input-side strobe of port A in mode 2) |
| irq | output | 1 | Interrupt request, level, active high |

## Verification
A wrong mode register shows at once at the pins. The output enables, and the ready level set by the mode word, are wrong right after the edge that took the control write. A wrong follow-up-word flag (direction or mask pending) shows one control write later, when a direction or mask word is taken as a mode or interrupt word; this changes pb_oe or irq at that edge. Handshake state errors show on the ready line at the strobe edge, or at the next data access, or as a wrong latched value on the following read. Interrupt state errors show on irq at the edge after the pin change or strobe rise.

// File: rtl/dual_pio.sv
module dual_pio #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         cs_n,
  input  logic         iorq_n,
  input  logic         rd_n,
  input  logic         m1_n,
  input  logic [1:0]   addr,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  output logic         a_rdy,
  input  logic         a_stb_n,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  output logic         b_rdy,
  input  logic         b_stb_n,
  output logic         irq
);
  localparam logic [1:0] M_OUT = 2'd0;
  localparam logic [1:0] M_IN  = 2'd1;
  localparam logic [1:0] M_BI  = 2'd2;
  localparam logic [1:0] M_BIT = 2'd3;

  logic srst, wr, rd, a2;
  logic [1:0][1:0]   mode;
  logic [1:0][W-1:0] oreg, ireg, dir, mask, pin, oe;
  logic [1:0] ien, andsel, hilvl, want_dir, want_mask, rdy, pend, bitirq;
  logic [1:0] stb_n, stb_q, fall, rise, cond, wr_dat, rd_dat, wr_ctl, acc;

  assign srst  = ~m1_n & rd_n & iorq_n;
  assign wr    = ~cs_n & ~iorq_n & rd_n & m1_n;
  assign rd    = ~cs_n & ~iorq_n & ~rd_n & m1_n;
  assign a2    = mode[0] == M_BI;
  assign pin   = {pb_in, pa_in};
  assign stb_n = {b_stb_n, a_stb_n};
  assign fall  = stb_q & ~stb_n;
  assign rise  = ~stb_q & stb_n;

  assign acc[0] = din[7:6] != M_BI || mode[1] == M_BIT;
  assign acc[1] = din[7:6] != M_BI && (!a2 || din[7:6] == M_BIT);

  for (genvar gi = 0; gi < 2; gi++) begin : g_port
    logic [W-1:0] hit;
    assign wr_dat[gi] = wr & ~addr[1] & (addr[0] == 1'(gi));
    assign rd_dat[gi] = rd & ~addr[1] & (addr[0] == 1'(gi));
    assign wr_ctl[gi] = wr &  addr[1] & (addr[0] == 1'(gi));
    assign hit        = mask[gi] & ~(pin[gi] ^ {W{hilvl[gi]}});
    assign cond[gi]   = andsel[gi] ? (mask[gi] != '0 && hit == mask[gi]) : (hit != '0);
    always_comb begin
      case (mode[gi])
        M_OUT:   oe[gi] = '1;
        M_IN:    oe[gi] = '0;
        M_BI:    oe[gi] = {W{~stb_n[gi]}};
        default: oe[gi] = ~dir[gi];
      endcase
    end
  end

  assign pa_out = oreg[0];
  assign pb_out = oreg[1];
  assign pa_oe  = oe[0];
  assign pb_oe  = oe[1];
  assign a_rdy  = rdy[0];
  assign b_rdy  = rdy[1];
  assign irq    = |(pend & ien) | |bitirq;

  always_comb begin
    dout = '0;
    if (rd && !addr[1]) begin
      case (mode[addr[0]])
        M_OUT:   dout = oreg[addr[0]];
        M_BIT:   dout = (pin[addr[0]] & dir[addr[0]]) | (oreg[addr[0]] & ~dir[addr[0]]);
        default: dout = ireg[addr[0]];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      mode      <= {M_IN, M_IN};
      oreg      <= '0;
      ireg      <= '0;
      dir       <= '1;
      mask      <= '0;
      ien       <= '0;
      andsel    <= '0;
      hilvl     <= '0;
      want_dir  <= '0;
      want_mask <= '0;
      rdy       <= '0;
      pend      <= '0;
      bitirq    <= '0;
      stb_q     <= '1;
    end else begin
      stb_q <= stb_n;
      for (int i = 0; i < 2; i++) begin
        bitirq[i] <= ien[i] && mode[i] == M_BIT && cond[i];
        if (wr_dat[i]) begin
          oreg[i] <= din;
          pend[i] <= 1'b0;
          if (mode[i] == M_OUT || mode[i] == M_BI) rdy[i] <= 1'b1;
        end
        if (rd_dat[i]) begin
          pend[i] <= 1'b0;
          if (mode[i] == M_IN) rdy[i] <= 1'b1;
          if (mode[i] == M_BI) rdy[1] <= 1'b1;
        end
        if (wr_ctl[i]) begin
          if (want_dir[i]) begin
            dir[i]      <= din;
            want_dir[i] <= 1'b0;
          end else if (want_mask[i]) begin
            mask[i]      <= din;
            want_mask[i] <= 1'b0;
          end else if (din[3:0] == 4'hF) begin
            if (acc[i]) begin
              mode[i]     <= din[7:6];
              want_dir[i] <= din[7:6] == M_BIT;
              pend[i]     <= 1'b0;
              rdy[i]      <= din[7:6] == M_IN;
              if (i == 0) begin
                if (din[7:6] == M_BI) rdy[1] <= 1'b1;
                else if (a2)          rdy[1] <= 1'b0;
              end
            end
          end else if (din[3:0] == 4'h7) begin
            ien[i]       <= din[7];
            andsel[i]    <= din[6];
            hilvl[i]     <= din[5];
            want_mask[i] <= din[4];
            pend[i]      <= 1'b0;
          end
        end
      end
      if (mode[0] != M_BIT) begin
        if (fall[0]) begin
          rdy[0] <= 1'b0;
          if (mode[0] == M_IN) ireg[0] <= pa_in;
        end
        if (rise[0] && ien[0]) pend[0] <= 1'b1;
      end
      if (a2) begin
        if (fall[1]) begin
          rdy[1]  <= 1'b0;
          ireg[0] <= pa_in;
        end
        if (rise[1] && ien[0]) pend[0] <= 1'b1;
      end else if (mode[1] != M_BIT) begin
        if (fall[1]) begin
          rdy[1] <= 1'b0;
          if (mode[1] == M_IN) ireg[1] <= pb_in;
        end
        if (rise[1] && ien[1]) pend[1] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_pio_chk.sv
module dual_pio_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         srst,
  input logic         cs_n,
  input logic         iorq_n,
  input logic         rd_n,
  input logic         m1_n,
  input logic [1:0]   addr,
  input logic [W-1:0] pa_out,
  input logic         a_rdy,
  input logic         b_rdy,
  input logic         a_stb_n,
  input logic         b_stb_n,
  input logic         irq,
  input logic [1:0]   mode_a,
  input logic [1:0]   mode_b,
  input logic [1:0]   ien
);
  logic wr_a;
  assign wr_a = !cs_n && !iorq_n && rd_n && m1_n && addr == 2'd0;

  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (srst)
    $past(srst) |-> (!irq && !a_rdy && !b_rdy));

  assert_rdy_drop_R4: assert property (@(posedge clk) disable iff (srst)
    (mode_a != 2'd3 && $fell(a_stb_n)) |=> !a_rdy);

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (srst)
    !wr_a |=> $stable(pa_out));

  assert_bidir_in_rdy_R6: assert property (@(posedge clk) disable iff (srst)
    (mode_a == 2'd2 && $fell(b_stb_n)) |=> !b_rdy);

  assert_bidir_pair_R7: assert property (@(posedge clk) disable iff (srst)
    mode_a == 2'd2 |-> mode_b == 2'd3);

  assert_quiet_disabled_R12: assert property (@(posedge clk) disable iff (srst)
    ien == 2'b00 |=> !irq);
endmodule

bind dual_pio dual_pio_chk #(.W(W)) u_chk (
  .clk(clk), .srst(srst), .cs_n(cs_n), .iorq_n(iorq_n), .rd_n(rd_n), .m1_n(m1_n),
  .addr(addr), .pa_out(pa_out), .a_rdy(a_rdy), .b_rdy(b_rdy), .a_stb_n(a_stb_n),
  .b_stb_n(b_stb_n), .irq(irq), .mode_a(mode[0]), .mode_b(mode[1]), .ien(ien)
);

// File: tb/dual_pio_bench.sv
module dual_pio_bench;
  logic clk = 1'b0;
  logic cs_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic [7:0] pa_in = '0, pa_out, pa_oe, pb_in = '0, pb_out, pb_oe;
  logic a_rdy, b_rdy, irq;
  logic a_stb_n = 1'b1, b_stb_n = 1'b1;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_pio u_dual_pio (
    .clk(clk), .cs_n(cs_n), .iorq_n(iorq_n), .rd_n(rd_n), .m1_n(m1_n), .addr(addr),
    .din(din), .dout(dout), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .a_rdy(a_rdy),
    .a_stb_n(a_stb_n), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .b_rdy(b_rdy),
    .b_stb_n(b_stb_n), .irq(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    m1_n = 1'b0; a_stb_n = 1'b1; b_stb_n = 1'b1; pa_in = '0; pb_in = '0;
    repeat (2) @(negedge clk);
    m1_n = 1'b1;
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; iorq_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; iorq_n = 1'b1;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; iorq_n = 1'b0; rd_n = 1'b0; addr = a;
    #5 v = dout;
    @(negedge clk);
    cs_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic strobe(bit port_b);
    @(negedge clk);
    if (port_b) b_stb_n = 1'b0; else a_stb_n = 1'b0;
    @(negedge clk);
    b_stb_n = 1'b1; a_stb_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    chk("R2 pa_oe", pa_oe, 8'h00);
    chk("R2 pb_oe", pb_oe, 8'h00);
    chk("R2 rdy", {6'd0, a_rdy, b_rdy}, 8'h00);
    chk("R2 irq", {7'd0, irq}, 8'h00);
    bus_rd(2'd0, v); chk("R2 A input reg", v, 8'h00);
    bus_rd(2'd2, v); chk("R1 control read", v, 8'h00);
    chk("R1 idle dout", dout, 8'h00);
  endtask

  task automatic t_output();
    logic [7:0] v;
    do_reset();
    bus_wr(2'd2, 8'h0F);
    chk("R3 mode0 oe", pa_oe, 8'hFF);
    chk("R4 rdy idle", {7'd0, a_rdy}, 8'h00);
    bus_wr(2'd0, 8'h5A);
    chk("R4 pins", pa_out, 8'h5A);
    chk("R4 rdy up", {7'd0, a_rdy}, 8'h01);
    bus_rd(2'd0, v); chk("R1 data read", v, 8'h5A);
    @(negedge clk); a_stb_n = 1'b0;
    @(negedge clk); chk("R4 rdy drop", {7'd0, a_rdy}, 8'h00);
    a_stb_n = 1'b1;
    @(negedge clk); chk("R4 pins held", pa_out, 8'h5A);
    bus_wr(2'd2, 8'h03);
    chk("R3 undefined word ignored", pa_oe, 8'hFF);
  endtask

  task automatic t_input();
    logic [7:0] v;
    do_reset();
    bus_wr(2'd2, 8'h4F);
    chk("R5 rdy on entry", {7'd0, a_rdy}, 8'h01);
    chk("R5 oe", pa_oe, 8'h00);
    pa_in = 8'hC3;
    strobe(1'b0);
    chk("R5 rdy after strobe", {7'd0, a_rdy}, 8'h00);
    pa_in = 8'h00;
    bus_rd(2'd0, v); chk("R5 latched", v, 8'hC3);
    chk("R5 rdy after read", {7'd0, a_rdy}, 8'h01);
  endtask

  task automatic t_bidir();
    logic [7:0] v;
    do_reset();
    bus_wr(2'd3, 8'hCF); bus_wr(2'd3, 8'hFF);
    bus_wr(2'd2, 8'h8F);
    chk("R6 rdy on entry", {6'd0, a_rdy, b_rdy}, 8'h01);
    chk("R6 oe idle", pa_oe, 8'h00);
    bus_wr(2'd0, 8'h55);
    chk("R6 a_rdy up", {7'd0, a_rdy}, 8'h01);
    @(negedge clk); a_stb_n = 1'b0;
    #1 chk("R6 drive on strobe", pa_oe, 8'hFF);
    chk("R6 out value", pa_out, 8'h55);
    @(negedge clk); chk("R6 a_rdy drop", {7'd0, a_rdy}, 8'h00);
    a_stb_n = 1'b1;
    #1 chk("R6 release", pa_oe, 8'h00);
    pa_in = 8'hA3;
    strobe(1'b1);
    chk("R6 b_rdy drop", {7'd0, b_rdy}, 8'h00);
    pa_in = 8'h00;
    bus_rd(2'd0, v); chk("R6 latched in", v, 8'hA3);
    chk("R6 b_rdy up", {7'd0, b_rdy}, 8'h01);
    bus_wr(2'd3, 8'h0F);
    chk("R7 B held in bit mode", pb_oe, 8'h00);
  endtask

  task automatic t_restrict();
    do_reset();
    bus_wr(2'd3, 8'h0F);
    chk("R7 B mode0", pb_oe, 8'hFF);
    bus_wr(2'd3, 8'h8F);
    chk("R7 B mode2 ignored", pb_oe, 8'hFF);
    bus_wr(2'd2, 8'h0F);
    bus_wr(2'd2, 8'h8F);
    chk("R7 A mode2 refused", pa_oe, 8'hFF);
  endtask

  task automatic t_bitmode();
    logic [7:0] v;
    do_reset();
    bus_wr(2'd3, 8'hCF); bus_wr(2'd3, 8'h0F);
    chk("R8 oe from dir", pb_oe, 8'hF0);
    bus_wr(2'd1, 8'hA5);
    chk("R8 out reg", pb_out, 8'hA5);
    pb_in = 8'h3C;
    bus_rd(2'd1, v); chk("R8 mixed read", v, 8'hAC);
  endtask

  task automatic t_bit_irq();
    do_reset();
    bus_wr(2'd3, 8'hCF); bus_wr(2'd3, 8'hFF);
    bus_wr(2'd3, 8'hF7); bus_wr(2'd3, 8'h03);
    pb_in = 8'h01;
    @(negedge clk); @(negedge clk);
    chk("R10 AND partial", {7'd0, irq}, 8'h00);
    pb_in = 8'h03;
    @(negedge clk); chk("R10 AND true", {7'd0, irq}, 8'h01);
    pb_in = 8'h02;
    @(negedge clk); chk("R10 AND false", {7'd0, irq}, 8'h00);
    bus_wr(2'd3, 8'h97); bus_wr(2'd3, 8'h0C);
    pb_in = 8'hFF;
    @(negedge clk); @(negedge clk);
    chk("R9 OR low idle", {7'd0, irq}, 8'h00);
    pb_in = 8'hFB;
    @(negedge clk); chk("R9 OR low hit", {7'd0, irq}, 8'h01);
    bus_wr(2'd3, 8'hF7); bus_wr(2'd3, 8'h00);
    @(negedge clk); @(negedge clk);
    chk("R10 empty mask", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_hs_irq();
    do_reset();
    bus_wr(2'd2, 8'h0F); bus_wr(2'd2, 8'h87);
    bus_wr(2'd0, 8'h11);
    strobe(1'b0);
    chk("R11 strobe irq", {7'd0, irq}, 8'h01);
    bus_wr(2'd0, 8'h22);
    chk("R11 cleared by write", {7'd0, irq}, 8'h00);
    bus_wr(2'd3, 8'h0F);
    bus_wr(2'd1, 8'h33);
    strobe(1'b1);
    chk("R12 B disabled", {7'd0, irq}, 8'h00);
    bus_wr(2'd2, 8'h07);
    strobe(1'b0);
    chk("R12 A disabled", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_output();
    t_input();
    t_bidir();
    t_restrict();
    t_bitmode();
    t_bit_irq();
    t_hs_irq();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule